// File: doc/BRIEF.md
# Dual-Constant 8-Bit Event Timer

The block is an 8-bit up-counter with two programmable time constants that are compared with the count all the time. Each comparison can set a flag, raise an interrupt, change one waveform output and, when selected, restart the count. A third flag marks a wrap of the counter from its top value to zero. Software reaches every register through a byte-wide register bus with one address, a write strobe and a read strobe. The read data follows the address without a clock.

Count pulses come from one of several prescaler tap enables, on their falling edge, or from an external clock pin, on its rising edge, its falling edge or both. An external reset pin can be selected as the clear source. Both external pins pass through a two-flop synchronizer. A compare match does not take effect in the cycle where the count reaches a constant. It takes effect on the next count pulse, so a counter cleared on match A repeats every constantA + 1 pulses.

Top module: `evtmr_top`

## Requirements
- R1: After reset the count, the control register, the output-action register, the flags and the waveform output are all 0, and both time constants are 0xFF.
- R2: Control bits [2:0] pick the count pulse source. Code k (1..3) counts falling edges of tap k-1. Code 4 counts rising edges of the external clock, code 5 its falling edges and code 6 both. Codes 0 and 7 stop the count. Each pulse adds one to the count.
- R3: Flag A (flag register bit 0) is set on the count pulse that arrives while the count equals constant A. Flag B (bit 1) works the same way with constant B. Reaching the value does not set the flag; only that next pulse does.
- R4: Control bits [4:3] pick the clear source: 0 none, 1 match A, 2 match B, 3 rising edge of the external reset pin. A clear on match replaces that pulse's increment, so the count returns to 0.
- R5: Output-action bits [1:0] apply on match A and bits [3:2] on match B. The codes are 0 keep, 1 drive low, 2 drive high, 3 toggle. When both matches occur on the same pulse, the action of match A decides the output.
- R6: The overflow flag (bit 2) is set when an increment takes the count from 0xFF to 0x00.
- R7: A bus write to the count register takes priority over an increment or a clear in the same cycle. The written value is stored exactly.
- R8: A flag clears only when 0 is written to its bit after a bus read has returned that bit as 1. Writing 0 without such a read, or writing 1, leaves the flag unchanged. A flag event in the same cycle wins over the clear.
- R9: Interrupt outputs for match A, match B and overflow equal their flag ANDed with control bit 5, 6 and 7 respectively.
- R10: A change on the external clock or external reset pin acts on the count at the third rising clock edge after the change.
- R11: The registers sit at these addresses: 0 control, 1 output actions, 2 flags, 3 count, 4 constant A, 5 constant B. Unused bits and addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address for reads and writes |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms flag clearing) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |
| tapIn | input | NUM_TAPS | Prescaler tap levels; a falling edge is a count pulse |
| extClkIn | input | 1 | External count clock pin |
| extRstIn | input | 1 | External counter clear pin |
| waveOut | output | 1 | Waveform output driven by compare actions |
| irqMatchA | output | 1 | Match A interrupt request |
| irqMatchB | output | 1 | Match B interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
Directed sequences drive single tap pulses against a small constant. This separates the deferred match (the flag is still clear at count == constant) from an immediate one, and it measures the constant + 1 period of clear-on-match. Further directed cases put a count write on the same edge as a pulse, step the count through 0xFE and 0xFF to show the wrap together with the match on constant 0xFF, set equal constants with opposite actions to show which action wins, and move the external pins to expose the synchronizer delay. Random traffic then mixes tap toggles, external pin edges, register writes and flag read/write pairs. A cycle model in the bench checks it, so that races between writes, clears and pulses show up as readback, flag or output mismatches.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int TW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_CTL  = 3'd0;
  localparam logic [AW-1:0] ADDR_ACT  = 3'd1;
  localparam logic [AW-1:0] ADDR_FLG  = 3'd2;
  localparam logic [AW-1:0] ADDR_CNT  = 3'd3;
  localparam logic [AW-1:0] ADDR_CSTA = 3'd4;
  localparam logic [AW-1:0] ADDR_CSTB = 3'd5;

  typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOGGLE} outAct_e;
  typedef enum logic [1:0] {CLR_NONE, CLR_MATCH_A, CLR_MATCH_B, CLR_EXT} clrSrc_e;

  typedef struct packed {
    logic          load;
    logic          clear;
    logic          inc;
    logic          wrConstA;
    logic          wrConstB;
    logic [TW-1:0] data;
  } cntCmd_t;
endpackage

// File: rtl/evtmr_datapath.sv
module evtmr_datapath
  import evtmr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  cntCmd_t       cmd,
  output logic [TW-1:0] count,
  output logic [TW-1:0] constA,
  output logic [TW-1:0] constB,
  output logic          eqA,
  output logic          eqB,
  output logic          atMax
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      constA <= '1;
      constB <= '1;
    end else begin
      if (cmd.load)       count <= cmd.data;
      else if (cmd.clear) count <= '0;
      else if (cmd.inc)   count <= count + 1'b1;
      if (cmd.wrConstA) constA <= cmd.data;
      if (cmd.wrConstB) constB <= cmd.data;
    end
  end

  assign eqA   = (count == constA);
  assign eqB   = (count == constB);
  assign atMax = &count;
endmodule

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
#(
  parameter int NUM_TAPS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AW-1:0]       addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [TW-1:0]       wrData,
  output logic [TW-1:0]       rdData,
  input  logic [NUM_TAPS-1:0] tapIn,
  input  logic                extClkIn,
  input  logic                extRstIn,
  input  logic [TW-1:0]       count,
  input  logic [TW-1:0]       constA,
  input  logic [TW-1:0]       constB,
  input  logic                eqA,
  input  logic                eqB,
  input  logic                atMax,
  output cntCmd_t             cmd,
  output logic                waveOut,
  output logic                irqMatchA,
  output logic                irqMatchB,
  output logic                irqOvf,
  output logic                evMatchA,
  output logic                evMatchB,
  output logic                evOvf,
  output logic [2:0]          flagVec
);
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = SEL_W'(NUM_TAPS + 1);
  localparam logic [SEL_W-1:0] SEL_EXT_FALL = SEL_W'(NUM_TAPS + 2);
  localparam logic [SEL_W-1:0] SEL_EXT_BOTH = SEL_W'(NUM_TAPS + 3);

  logic [TW-1:0]       ctlReg;
  logic [3:0]          actReg;
  logic [2:0]          flags;
  logic [2:0]          armed;
  logic [NUM_TAPS-1:0] tapPrev;
  logic [NUM_TAPS-1:0] tapFall;
  logic [SYNC_STAGES:0] clkPipe;
  logic [SYNC_STAGES:0] rstPipe;

  logic [SEL_W-1:0] clkSel;
  clrSrc_e          clrSel;
  logic             extRise, extFall, extRstRise;
  logic             tick, clrReq, ldCnt, flgWr;
  logic [2:0]       events;

  assign clkSel = ctlReg[2:0];
  assign clrSel = clrSrc_e'(ctlReg[4:3]);

  // Falling-edge detect per prescaler tap
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTapEdge
    assign tapFall[g] = tapPrev[g] & ~tapIn[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapPrev <= '0;
      clkPipe <= '0;
      rstPipe <= '0;
    end else begin
      tapPrev <= tapIn;
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], extClkIn};
      rstPipe <= {rstPipe[SYNC_STAGES-1:0], extRstIn};
    end
  end

  assign extRise    =  clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign extFall    = ~clkPipe[SYNC_STAGES-1] &  clkPipe[SYNC_STAGES];
  assign extRstRise =  rstPipe[SYNC_STAGES-1] & ~rstPipe[SYNC_STAGES];

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (clkSel == SEL_W'(i + 1)) tick = tapFall[i];
    if (clkSel == SEL_EXT_RISE) tick = extRise;
    if (clkSel == SEL_EXT_FALL) tick = extFall;
    if (clkSel == SEL_EXT_BOTH) tick = extRise | extFall;
  end

  // Deferred match: qualified by the next count pulse
  assign evMatchA = tick & eqA;
  assign evMatchB = tick & eqB;

  always_comb begin
    unique case (clrSel)
      CLR_MATCH_A: clrReq = evMatchA;
      CLR_MATCH_B: clrReq = evMatchB;
      CLR_EXT:     clrReq = extRstRise;
      default:     clrReq = 1'b0;
    endcase
  end

  assign ldCnt = wrEn && (addr == ADDR_CNT);
  assign flgWr = wrEn && (addr == ADDR_FLG);

  always_comb begin
    cmd          = '0;
    cmd.data     = wrData;
    cmd.load     = ldCnt;
    cmd.clear    = ~ldCnt & clrReq;
    cmd.inc      = ~ldCnt & ~clrReq & tick;
    cmd.wrConstA = wrEn && (addr == ADDR_CSTA);
    cmd.wrConstB = wrEn && (addr == ADDR_CSTB);
  end

  assign evOvf  = cmd.inc & atMax;
  assign events = {evOvf, evMatchB, evMatchA};

  function automatic logic applyAct(input logic cur, input outAct_e act);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg  <= '0;
      actReg  <= '0;
      flags   <= '0;
      armed   <= '0;
      waveOut <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_CTL) ctlReg <= wrData;
      if (wrEn && addr == ADDR_ACT) actReg <= wrData[3:0];

      for (int i = 0; i < 3; i++)
        flags[i] <= events[i] | (flags[i] & ~(flgWr & ~wrData[i] & armed[i]));

      if (rdEn && addr == ADDR_FLG) armed <= flags;
      else if (flgWr)               armed <= '0;

      if (evMatchA)      waveOut <= applyAct(waveOut, outAct_e'(actReg[1:0]));
      else if (evMatchB) waveOut <= applyAct(waveOut, outAct_e'(actReg[3:2]));
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTL:  rdData = ctlReg;
      ADDR_ACT:  rdData = {4'b0, actReg};
      ADDR_FLG:  rdData = {5'b0, flags};
      ADDR_CNT:  rdData = count;
      ADDR_CSTA: rdData = constA;
      ADDR_CSTB: rdData = constB;
      default:   rdData = '0;
    endcase
  end

  assign irqMatchA = flags[0] & ctlReg[5];
  assign irqMatchB = flags[1] & ctlReg[6];
  assign irqOvf    = flags[2] & ctlReg[7];
  assign flagVec   = flags;
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int NUM_TAPS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic [NUM_TAPS-1:0] tapIn,
  input  logic                extClkIn,
  input  logic                extRstIn,
  output logic                waveOut,
  output logic                irqMatchA,
  output logic                irqMatchB,
  output logic                irqOvf
);
  cntCmd_t       cmd;
  logic [TW-1:0] count, constA, constB;
  logic          eqA, eqB, atMax;
  logic          evMatchA, evMatchB, evOvf;
  logic [2:0]    flagVec;

  evtmr_ctrl #(.NUM_TAPS(NUM_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .tapIn(tapIn), .extClkIn(extClkIn),
    .extRstIn(extRstIn), .count(count), .constA(constA), .constB(constB),
    .eqA(eqA), .eqB(eqB), .atMax(atMax), .cmd(cmd), .waveOut(waveOut),
    .irqMatchA(irqMatchA), .irqMatchB(irqMatchB), .irqOvf(irqOvf),
    .evMatchA(evMatchA), .evMatchB(evMatchB), .evOvf(evOvf), .flagVec(flagVec)
  );

  evtmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count), .constA(constA),
    .constB(constB), .eqA(eqA), .eqB(eqB), .atMax(atMax)
  );
endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker
  import evtmr_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] addr,
  input logic          wrEn,
  input logic [TW-1:0] wrData,
  input logic [TW-1:0] count,
  input logic          waveOut,
  input logic          evMatchA,
  input logic          evMatchB,
  input logic          evOvf,
  input logic [2:0]    flagVec,
  input logic          irqMatchA
);
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CNT) |=> (count == $past(wrData)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == 8'($past(count) + 8'd1)) || (count == 8'd0)
                        || $past(wrEn && addr == ADDR_CNT));

  assert_flag_a_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    evMatchA |=> flagVec[0]);

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    evOvf |=> (count == 8'd0) && flagVec[2]);

  assert_wave_on_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(waveOut) |-> $past(evMatchA || evMatchB));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqMatchA |-> flagVec[0]);
endmodule

bind evtmr_top evtmr_checker u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .count(count), .waveOut(waveOut), .evMatchA(evMatchA), .evMatchB(evMatchB),
  .evOvf(evOvf), .flagVec(flagVec), .irqMatchA(irqMatchA)
);

// File: tb/tb_evtmr_top.sv
module tb_evtmr_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] tapIn = 3'b111;
  logic       extClkIn = 1'b0, extRstIn = 1'b0;
  logic       waveOut, irqMatchA, irqMatchB, irqOvf;

  int nChecks = 0, nFail = 0;
  bit modelOn = 0;

  always #5 clk = ~clk;

  evtmr_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .tapIn(tapIn), .extClkIn(extClkIn),
    .extRstIn(extRstIn), .waveOut(waveOut), .irqMatchA(irqMatchA),
    .irqMatchB(irqMatchB), .irqOvf(irqOvf)
  );

  // Reference model built from the requirements
  logic [7:0] mCnt, mA, mB, mCtl;
  logic [3:0] mAct;
  logic [2:0] mFlg, mArm, mTapPrev, mEc, mEr;
  logic       mWave;

  function automatic logic actOf(input logic cur, input logic [1:0] c);
    case (c)
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCtl;
      3'd1: return {4'b0, mAct};
      3'd2: return {5'b0, mFlg};
      3'd3: return mCnt;
      3'd4: return mA;
      3'd5: return mB;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [2:0] tf, ev, nf;
    logic eR, eF, rR, tk, ma, mb, clr, ld, inc, fw;
    if (!rstN) begin
      mCnt = 0; mA = 8'hFF; mB = 8'hFF; mCtl = 0; mAct = 0; mFlg = 0; mArm = 0;
      mWave = 0; mTapPrev = 0; mEc = 0; mEr = 0;
    end else begin
      tf = mTapPrev & ~tapIn;
      eR = mEc[1] & ~mEc[2]; eF = ~mEc[1] & mEc[2]; rR = mEr[1] & ~mEr[2];
      case (mCtl[2:0])
        3'd1: tk = tf[0];
        3'd2: tk = tf[1];
        3'd3: tk = tf[2];
        3'd4: tk = eR;
        3'd5: tk = eF;
        3'd6: tk = eR | eF;
        default: tk = 0;
      endcase
      ma  = tk && (mCnt == mA);
      mb  = tk && (mCnt == mB);
      clr = (mCtl[4:3] == 2'd1 && ma) || (mCtl[4:3] == 2'd2 && mb) || (mCtl[4:3] == 2'd3 && rR);
      ld  = wrEn && addr == 3'd3;
      inc = tk && !clr && !ld;
      ev  = {inc && mCnt == 8'hFF, mb, ma};
      fw  = wrEn && addr == 3'd2;
      if (ma) mWave = actOf(mWave, mAct[1:0]);
      else if (mb) mWave = actOf(mWave, mAct[3:2]);
      for (int i = 0; i < 3; i++) nf[i] = ev[i] | (mFlg[i] & ~(fw & ~wrData[i] & mArm[i]));
      if (rdEn && addr == 3'd2) mArm = mFlg;
      else if (fw) mArm = 0;
      mFlg = nf;
      if (ld) mCnt = wrData;
      else if (clr) mCnt = 0;
      else if (inc) mCnt = mCnt + 8'd1;
      if (wrEn && addr == 3'd0) mCtl = wrData;
      if (wrEn && addr == 3'd1) mAct = wrData[3:0];
      if (wrEn && addr == 3'd4) mA = wrData;
      if (wrEn && addr == 3'd5) mB = wrData;
      mTapPrev = tapIn;
      mEc = {mEc[1:0], extClkIn};
      mEr = {mEr[1:0], extRstIn};
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic we, input logic re, input logic [7:0] d);
    @(negedge clk);
    if (modelOn) begin
      chk("R11 readback vs model", rdData, mRead(addr));
      chk("R5 waveform vs model", waveOut, mWave);
      chk("R9 irq A vs model", irqMatchA, mFlg[0] & mCtl[5]);
      chk("R9 irq B vs model", irqMatchB, mFlg[1] & mCtl[6]);
      chk("R9 irq ovf vs model", irqOvf, mFlg[2] & mCtl[7]);
    end
    addr = a; wrEn = we; rdEn = re; wrData = d;
  endtask

  task automatic peek(input logic [2:0] a, input logic re, output logic [7:0] d);
    cyc(a, 1'b0, re, 8'h00);
    #1 d = rdData;
  endtask

  task automatic tapTick();
    cyc(3'd3, 1'b0, 1'b0, 8'h00);
    tapIn[0] = 1'b0;
    cyc(3'd3, 1'b0, 1'b0, 8'h00);
    tapIn[0] = 1'b1;
  endtask

  initial begin : watchdog
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int r;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1; modelOn = 1;

    // R1 reset state, R11 unused address
    peek(3'd0, 0, d); chk("R1 control", d, 8'h00);
    peek(3'd1, 0, d); chk("R1 actions", d, 8'h00);
    peek(3'd2, 0, d); chk("R1 flags", d, 8'h00);
    peek(3'd3, 0, d); chk("R1 count", d, 8'h00);
    peek(3'd4, 0, d); chk("R1 constant A", d, 8'hFF);
    peek(3'd5, 0, d); chk("R1 constant B", d, 8'hFF);
    peek(3'd6, 0, d); chk("R11 unused address", d, 8'h00);
    chk("R1 waveform", waveOut, 0);

    // R2/R3/R4: constA=2, toggle on A, tap0, clear on A, irq A enabled
    cyc(3'd4, 1, 0, 8'h02);
    cyc(3'd1, 1, 0, 8'h03);
    cyc(3'd0, 1, 0, 8'h29);
    tapTick(); tapTick();
    peek(3'd3, 0, d); chk("R2 count after two tap pulses", d, 8'h02);
    peek(3'd2, 0, d); chk("R3 no flag while count equals constant", d, 8'h00);
    tapTick();
    peek(3'd3, 0, d); chk("R4 clear on match A", d, 8'h00);
    peek(3'd2, 0, d); chk("R3 flag A on next pulse", d, 8'h01);
    chk("R5 toggle on match A", waveOut, 1);
    chk("R9 irq A asserted", irqMatchA, 1);

    // R8 flag clear handshake
    cyc(3'd2, 1, 0, 8'h00);
    peek(3'd2, 0, d); chk("R8 write 0 without read keeps flag", d, 8'h01);
    peek(3'd2, 1, d);
    cyc(3'd2, 1, 0, 8'h00);
    peek(3'd2, 0, d); chk("R8 read-then-write-0 clears flag", d, 8'h00);
    chk("R9 irq A released", irqMatchA, 0);

    // R7 write coincides with a pulse
    cyc(3'd3, 1, 0, 8'h50);
    tapIn[0] = 1'b0;
    cyc(3'd3, 0, 0, 8'h00);
    tapIn[0] = 1'b1;
    peek(3'd3, 0, d); chk("R7 write wins over increment", d, 8'h50);

    // R6 wrap, with match on constant B = 0xFF
    cyc(3'd0, 1, 0, 8'h81);
    cyc(3'd3, 1, 0, 8'hFE);
    tapTick();
    peek(3'd3, 0, d); chk("R6 count at top", d, 8'hFF);
    tapTick();
    peek(3'd3, 0, d); chk("R6 count wrapped", d, 8'h00);
    peek(3'd2, 0, d); chk("R6 overflow and B flags", d, 8'h06);
    chk("R9 irq ovf asserted", irqOvf, 1);
    chk("R9 irq B masked", irqMatchB, 0);

    // R10 external clock through synchronizer
    cyc(3'd0, 1, 0, 8'h04);
    cyc(3'd3, 1, 0, 8'h10);
    cyc(3'd3, 0, 0, 8'h00);
    extClkIn = 1'b1;
    peek(3'd3, 0, d);
    peek(3'd3, 0, d); chk("R10 no count after two edges", d, 8'h10);
    peek(3'd3, 0, d); chk("R10 count at third edge", d, 8'h11);

    // R4 external reset clear
    cyc(3'd0, 1, 0, 8'h18);
    cyc(3'd3, 1, 0, 8'h33);
    cyc(3'd3, 0, 0, 8'h00);
    extRstIn = 1'b1;
    peek(3'd3, 0, d);
    peek(3'd3, 0, d); chk("R4 ext clear not yet", d, 8'h33);
    peek(3'd3, 0, d); chk("R4 ext clear applied", d, 8'h00);

    // R5 both matches: A drives low, B drives high
    cyc(3'd4, 1, 0, 8'h05);
    cyc(3'd5, 1, 0, 8'h05);
    cyc(3'd1, 1, 0, 8'h09);
    cyc(3'd0, 1, 0, 8'h01);
    cyc(3'd3, 1, 0, 8'h05);
    tapTick();
    chk("R5 match A action wins", waveOut, 0);
    peek(3'd3, 0, d); chk("R2 count after both matches", d, 8'h06);
    peek(3'd2, 0, d); chk("R3 both match flags", d & 8'h03, 8'h03);

    // Random traffic against the model
    for (int n = 0; n < 6000; n++) begin
      r = $urandom;
      case (r % 16)
        0:  cyc(3'd0, 1, 0, 8'($urandom));
        1:  cyc(3'd1, 1, 0, 8'($urandom));
        2:  cyc(3'd4, 1, 0, 8'($urandom % 12));
        3:  cyc(3'd5, 1, 0, 8'($urandom % 12));
        4:  cyc(3'd3, 1, 0, 8'($urandom % 10));
        5:  cyc(3'd2, 0, 1, 8'h00);
        6:  cyc(3'd2, 1, 0, 8'($urandom % 8));
        default: cyc(3'($urandom), 0, 0, 8'h00);
      endcase
      tapIn = 3'($urandom);
      if ($urandom % 3 == 0) extClkIn = ~extClkIn;
      if ($urandom % 29 == 0) extRstIn = ~extRstIn;
    end
    cyc(3'd3, 0, 0, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule